// File: doc/BRIEF.md
# Four-Bank Interleaved Pixel Fetcher

This block sits between a source-address generator and a bilinear weighting stage. Each clock it can take one fixed-point source coordinate (X and Y, each with integer and fractional parts). It then issues reads to four pixel memory banks at once, so the complete 2x2 neighbourhood around that coordinate comes back in a single access. The source image is split across the banks by row and column parity. Every 2x2 square therefore touches each bank exactly once, and no pixel is stored twice.

The four returned pixels are reordered into fixed upper-left, upper-right, lower-left and lower-right outputs. The fractional parts of X and Y are delayed to arrive with them and serve as the interpolation weights. A load mode uses the same coordinate port to write incoming source pixels. Each pixel goes into the one bank that its coordinate parity selects.

Top module: `pixq_top`

## Requirements
- R1: A pixel at integer column x and row y belongs to bank number {y[0], x[0]}: bank 0 (A) even row and even column, bank 1 (B) even row and odd column, bank 2 (C) odd row and even column, bank 3 (D) odd row and odd column. Bank b uses bit b of `bankRd`/`bankWr`, bits [b*22 +: 22] of `bankAddr` and bits [b*16 +: 16] of `bankRdData`. Each bank address holds the row index in its upper 11 bits and the column index in its lower 11 bits.
- R2: A valid input with `inLoad` high asserts exactly one `bankWr` bit, the one for the bank of the integer coordinate, one cycle after the input. That bank's address is {Y[19:9], X[19:9]} and `bankWrData` equals `inPix`.
- R3: A valid input with `inLoad` low asserts all four `bankRd` bits one cycle after the input. When X[8] is set, banks A and C use column X[19:9]+1, otherwise X[19:9]. When Y[8] is set, banks A and B use row Y[19:9]+1, otherwise Y[19:9]. All other bank columns and rows use X[19:9] and Y[19:9].
- R4: The integer part of each coordinate is taken by truncation. The fraction bits [7:0] never affect bank selection or addresses, so the anchor is always the upper-left pixel of the enclosing square.
- R5: Fetch inputs that are valid on consecutive cycles produce one complete neighbourhood per cycle on consecutive cycles.
- R6: `outUl`, `outUr`, `outLl` and `outLr` carry the pixels at (x,y), (x+1,y), (x,y+1) and (x+1,y+1) of the truncated anchor, whatever the anchor's parity.
- R7: A neighbour column index above IMG_W/2-1 or a neighbour row index above IMG_H/2-1 is clamped to that last index. With a 512-wide image, the right neighbour of column 511 therefore reads column 510, and the same holds for rows.
- R8: Bank read data is expected one cycle after the bank address. `outValid`, the four pixels and `outFracX`/`outFracY` (the input's bits [7:0]) appear three cycles after the fetch input.
- R9: While reset is asserted, and after it is released, `bankRd`, `bankWr` and `outValid` are zero until inputs arrive.
- R10: A load input never asserts `bankRd` and never produces `outValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Coordinate (and pixel, in load mode) is present |
| inLoad | input | 1 | 1 = write `inPix` to its bank, 0 = fetch neighbourhood |
| inX | input | 20 | Source X, integer [19:8], fraction [7:0] |
| inY | input | 20 | Source Y, integer [19:8], fraction [7:0] |
| inPix | input | 16 | Pixel to store in load mode |
| bankAddr | output | 88 | Four bank addresses, 22 bits each |
| bankRd | output | 4 | Per-bank read strobe |
| bankWr | output | 4 | Per-bank write strobe |
| bankWrData | output | 16 | Write data shared by all banks |
| bankRdData | input | 64 | Four bank read results, 16 bits each |
| outValid | output | 1 | Neighbourhood output is valid |
| outUl | output | 16 | Upper-left pixel |
| outUr | output | 16 | Upper-right pixel |
| outLl | output | 16 | Lower-left pixel |
| outLr | output | 16 | Lower-right pixel |
| outFracX | output | 8 | Horizontal weight |
| outFracY | output | 8 | Vertical weight |

## Verification
On every cycle, the assertions hold the following:
- at most one bank is written;
- reads and writes never share a cycle;
- every issued read turns into `outValid` exactly two cycles later;
- the A and C column indices and the A and B row indices never differ from their partner banks by more than one.

The following can only be shown by scenarios, in which the bench loads images through load mode and compares each fetched neighbourhood against a behavioural model:
- that the right pixel lands in each corner output for all four anchor parities;
- that fractions are ignored for addressing;
- that clamping at the right and bottom edges picks the expected pixels.

// File: rtl/pixq_pkg.sv
package pixq_pkg;
  localparam int NUM_BANKS = 4;

  typedef struct packed {
    logic       rdEn;     // fetch issued to all banks this cycle
    logic [3:0] wrMask;   // one-hot bank write this cycle
    logic       capture;  // bank data present, load output registers
    logic [1:0] sel;      // {yOdd, xOdd} of the anchor being captured
  } pixStrobe_t;
endpackage

// File: rtl/pixq_ctrl.sv
module pixq_ctrl
  import pixq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLoad,
  input  logic       inXOdd,
  input  logic       inYOdd,
  output pixStrobe_t strobe,
  output logic       outValid
);
  logic       rd1, cap2, v3;
  logic [3:0] wr1;
  logic [1:0] par1, par2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rd1  <= 1'b0;
      wr1  <= '0;
      par1 <= '0;
      cap2 <= 1'b0;
      par2 <= '0;
      v3   <= 1'b0;
    end else begin
      rd1  <= inValid && !inLoad;
      wr1  <= (inValid && inLoad) ? (4'b0001 << {inYOdd, inXOdd}) : 4'b0000;
      par1 <= {inYOdd, inXOdd};
      cap2 <= rd1;
      par2 <= par1;
      v3   <= cap2;
    end
  end

  assign strobe.rdEn    = rd1;
  assign strobe.wrMask  = wr1;
  assign strobe.capture = cap2;
  assign strobe.sel     = par2;
  assign outValid       = v3;

  // R2: a load touches one bank only
  p_single_bank_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wr1));

  // R10: never read and write in the same cycle
  p_read_write_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(rd1 && (|wr1)));

  // R8: each read becomes an output two cycles later
  p_out_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    rd1 |-> ##2 outValid);
endmodule

// File: rtl/pixq_dp.sv
module pixq_dp
  import pixq_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 8,
  parameter int PIX_W  = 16,
  parameter int IMG_W  = 512,
  parameter int IMG_H  = 512
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic                        inLoad,
  input  logic [INT_W+FRAC_W-1:0]     inX,
  input  logic [INT_W+FRAC_W-1:0]     inY,
  input  logic [PIX_W-1:0]            inPix,
  input  pixStrobe_t                  strobe,
  output logic [4*(2*(INT_W-1))-1:0]  bankAddr,
  output logic [PIX_W-1:0]            bankWrData,
  input  logic [4*PIX_W-1:0]          bankRdData,
  output logic [PIX_W-1:0]            outUl,
  output logic [PIX_W-1:0]            outUr,
  output logic [PIX_W-1:0]            outLl,
  output logic [PIX_W-1:0]            outLr,
  output logic [FRAC_W-1:0]           outFracX,
  output logic [FRAC_W-1:0]           outFracY
);
  localparam int CW     = INT_W + FRAC_W;
  localparam int IDX_W  = INT_W - 1;
  localparam int ADDR_W = 2 * IDX_W;
  localparam logic [IDX_W-1:0] LAST_COL = IDX_W'(IMG_W / 2 - 1);
  localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(IMG_H / 2 - 1);

  logic [IDX_W-1:0] xIdx, yIdx, xNext, yNext;
  logic             xOdd, yOdd;

  assign xIdx  = inX[CW-1:FRAC_W+1];
  assign yIdx  = inY[CW-1:FRAC_W+1];
  assign xOdd  = inX[FRAC_W];
  assign yOdd  = inY[FRAC_W];
  assign xNext = (xIdx >= LAST_COL) ? LAST_COL : xIdx + 1'b1;
  assign yNext = (yIdx >= LAST_ROW) ? LAST_ROW : yIdx + 1'b1;

  logic [ADDR_W-1:0] addrQ [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [IDX_W-1:0] colSel, rowSel;
    // banks in an even column/row parity take the neighbour index on odd anchors
    always_comb begin
      colSel = (!inLoad && xOdd && (b % 2 == 0)) ? xNext : xIdx;
      rowSel = (!inLoad && yOdd && (b / 2 == 0)) ? yNext : yIdx;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        addrQ[b] <= '0;
      else if (inValid) addrQ[b] <= {rowSel, colSel};
    end
    assign bankAddr[b*ADDR_W +: ADDR_W] = addrQ[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  bankWrData <= '0;
    else if (inValid && inLoad) bankWrData <= inPix;
  end

  // weight delay: two plain stages, third loads with the pixels
  logic [FRAC_W-1:0] fx1, fy1, fx2, fy2;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fx1 <= '0; fy1 <= '0; fx2 <= '0; fy2 <= '0;
      outFracX <= '0; outFracY <= '0;
    end else begin
      fx1 <= inX[FRAC_W-1:0];
      fy1 <= inY[FRAC_W-1:0];
      fx2 <= fx1;
      fy2 <= fy1;
      if (strobe.capture) begin
        outFracX <= fx2;
        outFracY <= fy2;
      end
    end
  end

  // reorder: corner k sits in bank (anchor parity XOR k)
  logic [PIX_W-1:0] corner [NUM_BANKS];
  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_route
    logic [1:0] bankOfCorner;
    assign bankOfCorner = strobe.sel ^ 2'(k);
    assign corner[k]    = bankRdData[bankOfCorner*PIX_W +: PIX_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outUl <= '0; outUr <= '0; outLl <= '0; outLr <= '0;
    end else if (strobe.capture) begin
      outUl <= corner[0];
      outUr <= corner[1];
      outLl <= corner[2];
      outLr <= corner[3];
    end
  end

  // R7: bank A column equals bank B column or one past it
  p_neighbour_col_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |-> (addrQ[0][IDX_W-1:0] == addrQ[1][IDX_W-1:0]) ||
                    (addrQ[0][IDX_W-1:0] == addrQ[1][IDX_W-1:0] + 1'b1));

  // R7: bank A row equals bank C row or one past it
  p_neighbour_row_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |-> (addrQ[0][ADDR_W-1:IDX_W] == addrQ[2][ADDR_W-1:IDX_W]) ||
                    (addrQ[0][ADDR_W-1:IDX_W] == addrQ[2][ADDR_W-1:IDX_W] + 1'b1));
endmodule

// File: rtl/pixq_top.sv
module pixq_top
  import pixq_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 8,
  parameter int PIX_W  = 16,
  parameter int IMG_W  = 512,
  parameter int IMG_H  = 512
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic                        inLoad,
  input  logic [INT_W+FRAC_W-1:0]     inX,
  input  logic [INT_W+FRAC_W-1:0]     inY,
  input  logic [PIX_W-1:0]            inPix,
  output logic [4*(2*(INT_W-1))-1:0]  bankAddr,
  output logic [3:0]                  bankRd,
  output logic [3:0]                  bankWr,
  output logic [PIX_W-1:0]            bankWrData,
  input  logic [4*PIX_W-1:0]          bankRdData,
  output logic                        outValid,
  output logic [PIX_W-1:0]            outUl,
  output logic [PIX_W-1:0]            outUr,
  output logic [PIX_W-1:0]            outLl,
  output logic [PIX_W-1:0]            outLr,
  output logic [FRAC_W-1:0]           outFracX,
  output logic [FRAC_W-1:0]           outFracY
);
  pixStrobe_t strobe;

  pixq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLoad(inLoad),
    .inXOdd(inX[FRAC_W]), .inYOdd(inY[FRAC_W]),
    .strobe(strobe), .outValid(outValid)
  );

  pixq_dp #(.INT_W(INT_W), .FRAC_W(FRAC_W), .PIX_W(PIX_W),
            .IMG_W(IMG_W), .IMG_H(IMG_H)) dp_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLoad(inLoad),
    .inX(inX), .inY(inY), .inPix(inPix), .strobe(strobe),
    .bankAddr(bankAddr), .bankWrData(bankWrData), .bankRdData(bankRdData),
    .outUl(outUl), .outUr(outUr), .outLl(outLl), .outLr(outLr),
    .outFracX(outFracX), .outFracY(outFracY)
  );

  assign bankRd = {4{strobe.rdEn}};
  assign bankWr = strobe.wrMask;
endmodule

// File: tb/pixq_top_tb.sv
module pixq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 22;
  localparam int PIX_W  = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inLoad = 1'b0;
  logic [19:0] inX = '0, inY = '0;
  logic [15:0] inPix = '0;
  logic [4*ADDR_W-1:0] bankAddr;
  logic [3:0]  bankRd, bankWr;
  logic [15:0] bankWrData;
  logic [63:0] bankRdData = '0;
  logic        outValid;
  logic [15:0] outUl, outUr, outLl, outLr;
  logic [7:0]  outFracX, outFracY;

  int vectors = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixq_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLoad(inLoad),
    .inX(inX), .inY(inY), .inPix(inPix), .bankAddr(bankAddr),
    .bankRd(bankRd), .bankWr(bankWr), .bankWrData(bankWrData),
    .bankRdData(bankRdData), .outValid(outValid),
    .outUl(outUl), .outUr(outUr), .outLl(outLl), .outLr(outLr),
    .outFracX(outFracX), .outFracY(outFracY)
  );

  // ---- behavioural bank memories (one-cycle synchronous read)
  logic [15:0] mem [4][int];
  always @(posedge clk) begin
    for (int b = 0; b < 4; b++) begin
      int a;
      a = int'(bankAddr[b*ADDR_W +: ADDR_W]);
      if (bankWr[b]) mem[b][a] = bankWrData;
      if (bankRd[b]) bankRdData[b*PIX_W +: PIX_W] <= mem[b].exists(a) ? mem[b][a] : 16'hBAD0;
    end
  end

  // ---- reference pipeline of applied inputs
  int pV[3], pL[3], pX[3], pY[3], pFx[3], pFy[3], pPix[3];
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) pV[i] <= 0;
    end else begin
      for (int i = 2; i > 0; i--) begin
        pV[i] <= pV[i-1]; pL[i] <= pL[i-1]; pX[i] <= pX[i-1]; pY[i] <= pY[i-1];
        pFx[i] <= pFx[i-1]; pFy[i] <= pFy[i-1]; pPix[i] <= pPix[i-1];
      end
      pV[0] <= int'(inValid); pL[0] <= int'(inLoad);
      pX[0] <= int'(inX[19:8]); pY[0] <= int'(inY[19:8]);
      pFx[0] <= int'(inX[7:0]); pFy[0] <= int'(inY[7:0]);
      pPix[0] <= int'(inPix);
    end
  end

  function automatic int gold(int x, int y);
    return (y * 523 + x * 17 + 3) & 16'hFFFF;
  endfunction

  function automatic int nb(int v, int lim);
    return (v + 1 >= lim) ? lim - 2 : v + 1;  // R7 edge clamp in pixel terms
  endfunction

  function automatic int expAddr(int b, int x, int y);
    int xi, yi;
    xi = x >> 1; yi = y >> 1;
    if ((x & 1) && !(b & 1)) xi = (xi + 1 > 255) ? 255 : xi + 1;
    if ((y & 1) && !(b & 2)) yi = (yi + 1 > 255) ? 255 : yi + 1;
    return (yi << 11) | xi;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  // ---- per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      chk(bankRd == 0 && bankWr == 0 && !outValid, "R9 reset", int'({bankRd, bankWr, outValid}), 0);
    end else begin
      // address stage
      if (pV[0] != 0 && pL[0] != 0) begin
        int bk;
        bk = ((pY[0] & 1) << 1) | (pX[0] & 1);
        chk(bankWr == 4'(1 << bk), "R1 R2 write bank", int'(bankWr), 1 << bk);
        chk(int'(bankAddr[bk*ADDR_W +: ADDR_W]) == (((pY[0] >> 1) << 11) | (pX[0] >> 1)),
            "R2 write address", int'(bankAddr[bk*ADDR_W +: ADDR_W]), ((pY[0] >> 1) << 11) | (pX[0] >> 1));
        chk(int'(bankWrData) == pPix[0], "R2 write data", int'(bankWrData), pPix[0]);
        chk(bankRd == 0, "R10 no read on load", int'(bankRd), 0);
      end else if (pV[0] != 0) begin
        chk(bankRd == 4'hF && bankWr == 0, "R3 read strobes", int'({bankRd, bankWr}), 8'hF0);
        for (int b = 0; b < 4; b++) begin
          int e;
          e = expAddr(b, pX[0], pY[0]);
          chk(int'(bankAddr[b*ADDR_W +: ADDR_W]) == e, "R3 R4 R7 read address",
              int'(bankAddr[b*ADDR_W +: ADDR_W]), e);
        end
      end else begin
        chk(bankRd == 0 && bankWr == 0, "R9 idle strobes", int'({bankRd, bankWr}), 0);
      end
      // output stage
      if (pV[2] != 0 && pL[2] == 0) begin
        int x, y, rx, ly;
        x = pX[2]; y = pY[2]; rx = nb(x, 512); ly = nb(y, 512);
        chk(outValid, "R5 R8 outValid", int'(outValid), 1);
        chk(int'(outUl) == gold(x, y),   "R6 upper-left",  int'(outUl), gold(x, y));
        chk(int'(outUr) == gold(rx, y),  "R6 R7 upper-right", int'(outUr), gold(rx, y));
        chk(int'(outLl) == gold(x, ly),  "R6 R7 lower-left",  int'(outLl), gold(x, ly));
        chk(int'(outLr) == gold(rx, ly), "R6 R7 lower-right", int'(outLr), gold(rx, ly));
        chk(int'(outFracX) == pFx[2] && int'(outFracY) == pFy[2], "R4 R8 weights",
            int'({outFracX, outFracY}), (pFx[2] << 8) | pFy[2]);
      end else begin
        chk(!outValid, "R10 R8 no output", int'(outValid), 0);
      end
    end
  end

  // ---- stimulus
  task automatic drive(bit ld, int x, int y, int fx, int fy);
    @(negedge clk);
    inValid = 1'b1; inLoad = ld;
    inX = 20'((x << 8) | fx); inY = 20'((y << 8) | fy);
    inPix = 16'(gold(x, y));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; inLoad = 1'b0;
    end
  endtask

  task automatic loadBox(int x0, int y0, int w, int h);
    for (int y = y0; y < y0 + h; y++)
      for (int x = x0; x < x0 + w; x++)
        drive(1'b1, x, y, (x * 41 + 3) & 255, (y * 13 + 200) & 255);  // R4 fraction ignored on load
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(2);
    // R1 R2: load four regions through the block
    loadBox(0, 0, 6, 6);
    loadBox(508, 0, 4, 4);
    loadBox(0, 508, 4, 4);
    loadBox(508, 508, 4, 4);
    idle(3);
    // R5 R6: back-to-back fetches over every anchor parity
    for (int y = 0; y < 5; y++)
      for (int x = 0; x < 5; x++)
        drive(1'b0, x, y, (x * 29 + y * 7) & 255, (y * 53 + 11) & 255);
    idle(4);
    // R7: right, bottom and corner edges
    for (int y = 0; y < 3; y++)
      for (int x = 509; x < 512; x++) drive(1'b0, x, y, 255, 0);
    for (int y = 509; y < 512; y++)
      for (int x = 0; x < 3; x++) drive(1'b0, x, y, 0, 255);
    drive(1'b0, 510, 510, 128, 128);
    drive(1'b0, 511, 511, 1, 254);
    idle(2);
    // R10: load and fetch interleaved, gaps in valid
    drive(1'b1, 5, 5, 0, 0);
    drive(1'b0, 3, 3, 200, 100);
    idle(1);
    drive(1'b0, 4, 1, 17, 99);
    idle(6);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule